// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits in front of a DRAM device and holds a small pool of pending memory requests. Each request carries a bank, a row, a column and a read/write flag. The block also keeps an internal copy of which row is open in each bank. From that copy it works out, for every stored request, the one command that would move the request forward. That command is a column read or write when the wanted row is already open, a precharge when a different row is open, and an activate when the bank is closed.

Every cycle the block offers at most one command. In its normal mode it serves ready column commands before row commands, and within either group the request that arrived first goes first. A mode input switches to plain arrival order, which makes the effect of row-hit priority on throughput easy to measure. A per-bank ready input stands in for all DRAM timing rules: a request whose bank is not ready is never chosen. An issued column command retires its request. An issued activate or precharge updates the open-row copy and leaves the request waiting.

Top module: `dram_req_sched`

## Requirements
- R1: After a synchronous active-low reset the pool is empty, every bank is closed, `cmd_valid` is 0, `cmd_type` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. It goes into the lowest-numbered slot that was free at the start of that cycle, and it cannot be chosen before the following cycle. `req_ready` is 0 exactly when all DEPTH slots are occupied, and a request offered then is dropped.
- R3: The command for a request is derived from its bank's state. An open bank holding the same row gives read (`cmd_type`=3) or write (`cmd_type`=4) as set by the write flag. An open bank holding another row gives precharge (2). A closed bank gives activate (1). No command is shown as 0.
- R4: A request is a candidate only while bit `bank` of `bank_rdy` is 1. With no candidate, `cmd_valid` is 0 and `cmd_type` is 0.
- R5: With `fcfs_mode`=0, a candidate whose command is a read or write is always chosen over any candidate needing a precharge or activate.
- R6: Within the group that wins, the candidate that arrived earliest is chosen.
- R7: With `fcfs_mode`=1, the earliest-arrived candidate is chosen whatever its command type.
- R8: Issuing a read or write frees that request's slot at the same edge. Issuing a precharge or activate leaves the request stored.
- R9: An issued activate marks its bank open with the request's row. An issued precharge marks its bank closed.
- R10: The command outputs are combinational from stored state and the present `bank_rdy` and `fcfs_mode`. `cmd_slot`, `cmd_bank`, `cmd_row` and `cmd_col` show the chosen request's slot and fields in the same cycle as `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcfs_mode | input | 1 | 1 selects plain arrival order, 0 selects row-hit-first |
| req_valid | input | 1 | A new request is offered |
| req_ready | output | 1 | A free slot exists |
| req_bank | input | 2 | Bank of the offered request |
| req_row | input | 8 | Row of the offered request |
| req_col | input | 6 | Column of the offered request |
| req_write | input | 1 | 1 for write, 0 for read |
| bank_rdy | input | 4 | Per-bank permission to issue this cycle |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_type | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_slot | output | 3 | Slot of the chosen request |
| cmd_bank | output | 2 | Bank of the chosen request |
| cmd_row | output | 8 | Row of the chosen request |
| cmd_col | output | 6 | Column of the chosen request |

## Verification
Two requests to the same bank and row show that one activate is followed by two column commands, oldest first. An older request for another row placed behind an open-row hit separates row-hit-first from arrival order. Replaying that same pool with `fcfs_mode` set shows the reverse order. Masking `bank_rdy` on the older bank shows that readiness, not age alone, makes a request a candidate. Long random streams over a few rows and banks, with sparse ready masks and mode changes, mix hits, conflicts and a full pool, and an arrival-ordered reference model predicts every command.

// File: rtl/frs_pkg.sv
// Shared constants and types for the row-hit-first command scheduler.
// Assumes a fixed bank count and row/column widths shared by every module.
package frs_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;

    // Command code seen on cmd_type; values are part of the port contract.
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4
    } cmd_e;

    // One stored memory request.
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
    } req_t;
endpackage

// File: rtl/sched_queue.sv
// Request pool with compact arrival ranks.
// Each occupied slot holds a rank 0..count-1; rank 0 is the oldest. Ranks of
// younger entries drop by one when an entry leaves, so ranks stay unique.
// Assumes enq_en is only raised while full is low and rm_slot is occupied.
module sched_queue
    import frs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enq_en,
    input  req_t                        enq_req,
    input  logic                        rm_en,
    input  logic [$clog2(DEPTH)-1:0]    rm_slot,
    output logic [DEPTH-1:0]            valid,
    output req_t                        ents [DEPTH],
    output logic [$clog2(DEPTH)-1:0]    ages [DEPTH],
    output logic                        full
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int AGE_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] free_idx;
    logic              free_got;

    assign full = (cnt == CNT_W'(DEPTH));

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        free_got = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid[i] && !free_got) begin
                free_idx = SLOT_W'(i);
                free_got = 1'b1;
            end
        end
    end

    // Retire, re-rank and insert entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            cnt   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
                ages[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (rm_en && (rm_slot == SLOT_W'(i))) begin
                    valid[i] <= 1'b0;
                end else if (valid[i] && rm_en && (ages[i] > ages[rm_slot])) begin
                    ages[i] <= ages[i] - 1'b1;
                end
            end
            if (enq_en) begin
                valid[free_idx] <= 1'b1;
                ents[free_idx]  <= enq_req;
                ages[free_idx]  <= AGE_W'(cnt - CNT_W'(rm_en));
            end
            cnt <= cnt + CNT_W'(enq_en) - CNT_W'(rm_en);
        end
    end

    // R2: the occupancy counter tracks the set of occupied slots.
    p_count_consistent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == CNT_W'($countones(valid)));

    // R2: nothing is written into a full pool.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt <= CNT_W'(DEPTH)) && ($past(enq_en) == 1'b0 || $past(rm_en)));

    // R8: only an occupied slot is retired.
    p_retire_occupied_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> valid[rm_slot]);
endmodule

// File: rtl/bank_table.sv
// Open-row record for every bank.
// An activate opens the bank at the given row; a precharge closes it.
// Assumes at most one row command per cycle.
module bank_table
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_act,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic [NBANK-1:0]  is_open,
    output logic [ROW_W-1:0]  open_row [NBANK]
);
    // Apply the issued row command to its bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= '0;
            for (int b = 0; b < NBANK; b++) open_row[b] <= '0;
        end else if (upd_en) begin
            is_open[upd_bank] <= upd_act;
            if (upd_act) open_row[upd_bank] <= upd_row;
        end
    end

    // R9: an activate leaves its bank open at the requested row.
    p_act_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_act) |=> is_open[$past(upd_bank)] &&
                                (open_row[$past(upd_bank)] == $past(upd_row)));

    // R9: a precharge leaves its bank closed.
    p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_act) |=> !is_open[$past(upd_bank)]);
endmodule

// File: rtl/oldest_sel.sv
// Picks the masked slot with the smallest arrival rank.
// Assumes ranks of masked slots are distinct.
module oldest_sel #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]         mask,
    input  logic [$clog2(DEPTH)-1:0] ages [DEPTH],
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [SLOT_W-1:0] best;

    // Linear scan keeping the smallest rank seen so far.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mask[i] && (!found || ages[i] < best)) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
                best  = ages[i];
            end
        end
    end
endmodule

// File: rtl/sched_pick.sv
// Classifies every stored request and selects the command to issue.
// Row-hit-first mode: oldest ready column command, else oldest ready row
// command. Arrival mode: oldest ready request of any kind.
module sched_pick
    import frs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fcfs_mode,
    input  logic [DEPTH-1:0]         valid,
    input  req_t                     ents [DEPTH],
    input  logic [$clog2(DEPTH)-1:0] ages [DEPTH],
    input  logic [NBANK-1:0]         is_open,
    input  logic [ROW_W-1:0]         open_row [NBANK],
    input  logic [NBANK-1:0]         bank_rdy,
    output logic                     sel_valid,
    output logic [$clog2(DEPTH)-1:0] sel_slot,
    output cmd_e                     sel_cmd
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] hit;
    cmd_e             ent_cmd [DEPTH];

    // Per-slot candidacy, row-hit test and required command.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cls
        assign elig[i]    = valid[i] && bank_rdy[ents[i].bank];
        assign hit[i]     = is_open[ents[i].bank] && (open_row[ents[i].bank] == ents[i].row);
        assign ent_cmd[i] = hit[i] ? (ents[i].wr ? CMD_WR : CMD_RD)
                          : (is_open[ents[i].bank] ? CMD_PRE : CMD_ACT);
    end

    logic              f_hit, f_miss, f_all;
    logic [SLOT_W-1:0] i_hit, i_miss, i_all;

    oldest_sel #(.DEPTH(DEPTH)) u_hit  (.mask(elig & hit),  .ages(ages), .found(f_hit),  .idx(i_hit));
    oldest_sel #(.DEPTH(DEPTH)) u_miss (.mask(elig & ~hit), .ages(ages), .found(f_miss), .idx(i_miss));
    oldest_sel #(.DEPTH(DEPTH)) u_all  (.mask(elig),        .ages(ages), .found(f_all),  .idx(i_all));

    // Apply the class priority chosen by the mode input.
    always_comb begin
        if (fcfs_mode) begin
            sel_valid = f_all;
            sel_slot  = i_all;
        end else if (f_hit) begin
            sel_valid = 1'b1;
            sel_slot  = i_hit;
        end else begin
            sel_valid = f_miss;
            sel_slot  = i_miss;
        end
        sel_cmd = sel_valid ? ent_cmd[sel_slot] : CMD_NONE;
    end

    // R5: in row-hit-first mode a row command never passes a ready hit.
    p_hit_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcfs_mode && (sel_cmd == CMD_ACT || sel_cmd == CMD_PRE)) |-> ((elig & hit) == '0));

    // R4: a chosen request always has its bank ready.
    p_bank_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> bank_rdy[ents[sel_slot].bank]);

    // R4: with no candidate nothing is chosen.
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> !sel_valid);
endmodule

// File: rtl/dram_req_sched.sv
// Top level of the row-hit-first DRAM command scheduler.
// Holds DEPTH requests, tracks open rows and offers one command per cycle.
// Assumes the consumer takes every command shown with cmd_valid high.
module dram_req_sched
    import frs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fcfs_mode,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [BANK_W-1:0]        req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     req_write,
    input  logic [NBANK-1:0]         bank_rdy,
    output logic                     cmd_valid,
    output logic [2:0]               cmd_type,
    output logic [$clog2(DEPTH)-1:0] cmd_slot,
    output logic [BANK_W-1:0]        cmd_bank,
    output logic [ROW_W-1:0]         cmd_row,
    output logic [COL_W-1:0]         cmd_col
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid;
    req_t              ents [DEPTH];
    logic [SLOT_W-1:0] ages [DEPTH];
    logic              full;
    logic [NBANK-1:0]  is_open;
    logic [ROW_W-1:0]  open_row [NBANK];
    logic              sel_valid;
    logic [SLOT_W-1:0] sel_slot;
    cmd_e              sel_cmd;
    req_t              new_req;
    logic              is_col, is_row;

    assign new_req   = '{bank: req_bank, row: req_row, col: req_col, wr: req_write};
    assign req_ready = !full;
    assign is_col    = (sel_cmd == CMD_RD) || (sel_cmd == CMD_WR);
    assign is_row    = (sel_cmd == CMD_ACT) || (sel_cmd == CMD_PRE);

    sched_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .enq_en  (req_valid && !full),
        .enq_req (new_req),
        .rm_en   (is_col),
        .rm_slot (sel_slot),
        .valid   (valid),
        .ents    (ents),
        .ages    (ages),
        .full    (full)
    );

    bank_table u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (is_row),
        .upd_act  (sel_cmd == CMD_ACT),
        .upd_bank (ents[sel_slot].bank),
        .upd_row  (ents[sel_slot].row),
        .is_open  (is_open),
        .open_row (open_row)
    );

    sched_pick #(.DEPTH(DEPTH)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .fcfs_mode (fcfs_mode),
        .valid     (valid),
        .ents      (ents),
        .ages      (ages),
        .is_open   (is_open),
        .open_row  (open_row),
        .bank_rdy  (bank_rdy),
        .sel_valid (sel_valid),
        .sel_slot  (sel_slot),
        .sel_cmd   (sel_cmd)
    );

    // Present the chosen request on the command outputs.
    assign cmd_valid = sel_valid;
    assign cmd_type  = sel_cmd;
    assign cmd_slot  = sel_slot;
    assign cmd_bank  = ents[sel_slot].bank;
    assign cmd_row   = ents[sel_slot].row;
    assign cmd_col   = ents[sel_slot].col;

    // R3: a column command only targets the row open in its bank.
    p_col_on_open_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_type == 3'd3 || cmd_type == 3'd4)) |->
            (is_open[cmd_bank] && open_row[cmd_bank] == cmd_row));

    // R10: a shown command always comes from an occupied slot.
    p_cmd_from_stored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> valid[cmd_slot]);
endmodule

// File: tb/tb_dram_req_sched.sv
// Bench for the row-hit-first scheduler: directed cases plus seeded random
// traffic, each cycle compared with an arrival-ordered reference model.
module tb_dram_req_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcfs_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic       req_write = 1'b0;
    logic [3:0] bank_rdy = '0;
    logic       cmd_valid;
    logic [2:0] cmd_type;
    logic [2:0] cmd_slot;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_row;
    logic [5:0] cmd_col;

    always #2 clk = ~clk;

    dram_req_sched dut (.*);

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    bit m_valid [8];
    int m_bank [8], m_row [8], m_col [8], m_seq [8];
    bit m_wr [8];
    bit m_open [4];
    int m_orow [4];
    int seq_ctr;
    int obs_type, obs_slot, obs_ready;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_valid[i] = 0;
        for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_orow[b] = 0; end
        seq_ctr = 0;
    endtask

    // Expected choice: slot (-1 none) and command code.
    task automatic model_pick(input logic [3:0] rdy, input bit mode, output int s, output int t);
        int bh, bm, ba;
        bh = -1; bm = -1; ba = -1;
        for (int i = 0; i < 8; i++) begin
            if (m_valid[i] && rdy[m_bank[i]]) begin
                bit h;
                h = m_open[m_bank[i]] && (m_orow[m_bank[i]] == m_row[i]);
                if (h && (bh < 0 || m_seq[i] < m_seq[bh])) bh = i;
                if (!h && (bm < 0 || m_seq[i] < m_seq[bm])) bm = i;
                if (ba < 0 || m_seq[i] < m_seq[ba]) ba = i;
            end
        end
        s = mode ? ba : ((bh >= 0) ? bh : bm);
        if (s < 0) t = 0;
        else if (m_open[m_bank[s]] && m_orow[m_bank[s]] == m_row[s]) t = m_wr[s] ? 4 : 3;
        else t = m_open[m_bank[s]] ? 2 : 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; bank_rdy = '0; fcfs_mode = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One cycle: drive at the falling edge, compare, then let the edge commit.
    task automatic step(input bit rq, input int b, input int r, input int c, input bit w,
                        input logic [3:0] rdy, input bit mode);
        int s, t, cnt, fr;
        @(negedge clk);
        req_valid = rq; req_bank = b[1:0]; req_row = r[7:0]; req_col = c[5:0];
        req_write = w; bank_rdy = rdy; fcfs_mode = mode;
        #1;
        model_pick(rdy, mode, s, t);
        cnt = 0; fr = -1;
        for (int i = 0; i < 8; i++) begin
            if (m_valid[i]) cnt++;
            else if (fr < 0) fr = i;
        end
        obs_type = cmd_type; obs_slot = cmd_slot; obs_ready = req_ready;
        chk(req_ready == (cnt < 8), "R2 req_ready", req_ready, cnt < 8);
        chk(cmd_valid == (t != 0), "R4 cmd_valid", cmd_valid, t != 0);
        if (mode) chk(cmd_type == t, "R7 cmd_type", cmd_type, t);
        else      chk(cmd_type == t, "R5 cmd_type", cmd_type, t);
        if (t != 0) begin
            chk(cmd_slot == s, "R6 cmd_slot", cmd_slot, s);
            chk(cmd_bank == m_bank[s] && cmd_row == m_row[s] && cmd_col == m_col[s],
                "R10 cmd fields", {cmd_bank, cmd_row, cmd_col},
                {m_bank[s][1:0], m_row[s][7:0], m_col[s][5:0]});
        end
        @(posedge clk);
        if (t == 3 || t == 4) m_valid[s] = 0;
        else if (t == 1) begin m_open[m_bank[s]] = 1; m_orow[m_bank[s]] = m_row[s]; end
        else if (t == 2) m_open[m_bank[s]] = 0;
        if (rq && cnt < 8) begin
            m_valid[fr] = 1; m_bank[fr] = b; m_row[fr] = r; m_col[fr] = c;
            m_wr[fr] = w; m_seq[fr] = seq_ctr; seq_ctr++;
        end
    endtask

    task automatic expect_cmd(input string tag, input int t, input int s);
        chk(obs_type == t, tag, obs_type, t);
        if (t != 0) chk(obs_slot == s, tag, obs_slot, s);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(cmd_valid == 0 && cmd_type == 0, "R1 idle after reset", cmd_type, 0);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

        // R3 R6 R8: one activate then two column commands in arrival order
        step(1, 0, 5, 1, 0, 4'h0, 0);
        step(1, 0, 5, 2, 1, 4'h0, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R3 activate closed bank", 1, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R6 older read first", 3, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R3 write hit", 4, 1);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R8 retired after column", 0, 0);

        // R5 R9: younger hit passes older conflict
        do_reset();
        step(1, 0, 5, 0, 0, 4'h0, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R9 activate", 1, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R9 row now open", 3, 0);
        step(1, 0, 9, 7, 0, 4'h0, 0);
        step(1, 0, 5, 3, 1, 4'h0, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R5 hit before older miss", 4, 1);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R3 precharge on conflict", 2, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R9 precharge closed bank", 1, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R8 row cmd kept entry", 3, 0);

        // R7: same pool in arrival mode
        do_reset();
        step(1, 0, 5, 0, 0, 4'h0, 1);
        step(0, 0, 0, 0, 0, 4'hF, 1);
        step(0, 0, 0, 0, 0, 4'hF, 1);
        step(1, 0, 9, 7, 0, 4'h0, 1);
        step(1, 0, 5, 3, 1, 4'h0, 1);
        step(0, 0, 0, 0, 0, 4'hF, 1); expect_cmd("R7 oldest conflict first", 2, 0);
        step(0, 0, 0, 0, 0, 4'hF, 1); expect_cmd("R7 activate for oldest", 1, 0);
        step(0, 0, 0, 0, 0, 4'hF, 1); expect_cmd("R7 oldest read", 3, 0);
        step(0, 0, 0, 0, 0, 4'hF, 1); expect_cmd("R7 then younger", 2, 1);

        // R4: bank readiness gates candidacy
        do_reset();
        step(1, 1, 1, 0, 0, 4'h0, 0);
        step(1, 2, 1, 0, 0, 4'h0, 0);
        step(0, 0, 0, 0, 0, 4'b0100, 0); expect_cmd("R4 only ready bank", 1, 1);
        step(0, 0, 0, 0, 0, 4'b0000, 0); expect_cmd("R4 none ready", 0, 0);

        // R2: new entry not eligible in its arrival cycle
        do_reset();
        step(1, 3, 2, 0, 0, 4'hF, 0); expect_cmd("R2 not same cycle", 0, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R2 eligible next cycle", 1, 0);

        // R2: full pool refuses further requests
        do_reset();
        for (int k = 0; k < 8; k++) step(1, k % 4, k, k, 0, 4'h0, 0);
        step(1, 3, 77, 9, 1, 4'h0, 0);
        chk(obs_ready == 0, "R2 full refuses", obs_ready, 0);
        step(0, 0, 0, 0, 0, 4'hF, 0); expect_cmd("R2 oldest after full", 1, 0);

        // Random traffic, both modes
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            bit rq, md;
            logic [3:0] rdy;
            rq  = ($urandom % 3) != 0;
            md  = ((k / 250) % 2) == 1;
            rdy = (($urandom % 4) == 0) ? 4'hF : 4'($urandom);
            step(rq, $urandom % 4, 1 + ($urandom % 3), $urandom % 64, $urandom % 2, rdy, md);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule